// File: doc/BRIEF.md
# Fixed-Point Vertex Transform Engine

This block streams 3D vertices through a fixed-point matrix. Each vertex arrives as one 64-bit word holding four signed 16-bit lanes: X in the lowest lane, then Y, then Z, then a homogeneous lane that software sets to 1. Three matrix rows of four signed Q13 coefficients each are held in internal registers. For every row the engine forms two signed dot-products over lane pairs and adds them with 32-bit wrap-around. It then shifts the total right arithmetically by 13 and keeps the low 16 bits as one output coordinate. The three coordinates of a vertex leave together as one 48-bit word.

Software loads the rows and a vertex count while the engine is idle, then pulses a start strobe. The engine accepts exactly that many vertices over a valid/ready input and delivers the same number of results over a valid/ready output. It raises a one-cycle completion pulse once the final result has been taken. The row evaluation is a three-stage pipeline: multiply, pair-sum, then rescale and pack. All three rows are computed side by side, so one vertex can enter every cycle.

Top module: `vertex_xform`

## Requirements
- R1: After reset, inReady, outValid, busy and done are all 0.
- R2: While idle, cfgWe with cfgRow equal to 0, 1 or 2 stores cfgData as that row. Bits [16k+15:16k] of cfgData hold coefficient k, which multiplies input lane k (bits [16k+15:16k] of inData). A write with cfgRow equal to 3 changes no stored row.
- R3: For each row, the low partial sum is c0*X + c1*Y and the high partial sum is c2*Z + c3*W. All products are signed 16x16. The row total is low plus high, taken modulo 2^32.
- R4: Each coordinate is the row total shifted right arithmetically by 13, truncated to its low 16 bits, with no saturation.
- R5: Row r's coordinate occupies outData[16r+15:16r], so row 0 is in the lowest 16 bits.
- R6: A run started with count N > 0 accepts exactly N input vertices and produces exactly N results. inReady stays low once N vertices have been accepted, even if inValid stays high.
- R7: done is high for exactly one cycle, in the cycle after the handshake of the last result. busy is low from that cycle on.
- R8: A start while the stored count is 0 raises done in the next cycle and accepts no vertex.
- R9: With outReady held high, one vertex is accepted every cycle. Its result is presented three cycles after its input handshake.
- R10: While outValid is high and outReady is low, outValid stays high and outData does not change.
- R11: cfgWe and cntWe are ignored while busy is high. Neither the stored rows nor the stored count change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Coefficient row write strobe |
| cfgRow | input | 2 | Row index for the coefficient write |
| cfgData | input | 64 | Four packed signed Q13 coefficients |
| cntWe | input | 1 | Vertex count write strobe |
| cntData | input | 16 | Vertex count for the next run |
| start | input | 1 | Begins a run when idle |
| inValid | input | 1 | Input vertex valid |
| inReady | output | 1 | Engine accepts an input vertex |
| inData | input | 64 | Packed input vertex (X, Y, Z, W lanes) |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Consumer accepts the result |
| outData | output | 48 | Three packed 16-bit coordinates |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that reset is applied before any stimulus. They also assume a consumer may hold outReady low for any length of time, while the producer may change inData freely except during a handshake. They do not assume that the W lane carries 1, so the stimulus also includes vertices with extreme lane values. Combined with the most negative and most positive coefficients, these make the 32-bit partial sums wrap. All inputs change only half a cycle away from the rising edge. Configuration writes are issued during a run only in the one test that checks they are ignored.

// File: rtl/vxf_pkg.sv
package vxf_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic adv;      // pipeline shifts this cycle
    logic take;     // an input vertex is accepted
    logic cfgLoad;  // coefficient row write permitted
    logic running;  // a run is in progress
  } dpCtl_t;

endpackage

// File: rtl/vxf_datapath.sv
module vxf_datapath
  import vxf_pkg::*;
#(
  parameter int LANE_W    = 16,
  parameter int LANES     = 4,
  parameter int ROWS      = 3,
  parameter int SHIFT     = 13,
  parameter int ROW_IDX_W = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtl_t                    ctl,
  input  logic [ROW_IDX_W-1:0]      cfgRow,
  input  logic [LANE_W*LANES-1:0]   cfgData,
  input  logic [LANE_W*LANES-1:0]   inData,
  output logic [LANE_W*ROWS-1:0]    outData
);

  localparam int VEC_W = LANE_W * LANES;
  localparam int OUT_W = LANE_W * ROWS;
  localparam int ACC_W = 2 * LANE_W;
  localparam int HALF  = LANES / 2;

  logic [ROWS-1:0][VEC_W-1:0] coefQ;
  logic signed [ACC_W-1:0] loN [ROWS];
  logic signed [ACC_W-1:0] hiN [ROWS];
  logic signed [ACC_W-1:0] loQ [ROWS];
  logic signed [ACC_W-1:0] hiQ [ROWS];
  logic signed [ACC_W-1:0] sumQ [ROWS];
  logic [OUT_W-1:0] outQ;

  // Coefficient rows, one register per row
  for (genvar r = 0; r < ROWS; r++) begin : gRow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        coefQ[r] <= '0;
      end else if (ctl.cfgLoad && cfgRow == ROW_IDX_W'(r)) begin
        coefQ[r] <= cfgData;
      end
    end
  end

  // Paired multiply-add per row: lower lanes and upper lanes
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      loN[r] = '0;
      hiN[r] = '0;
      for (int k = 0; k < LANES; k++) begin
        logic signed [ACC_W-1:0] cExt;
        logic signed [ACC_W-1:0] vExt;
        cExt = ACC_W'($signed(coefQ[r][k*LANE_W +: LANE_W]));
        vExt = ACC_W'($signed(inData[k*LANE_W +: LANE_W]));
        if (k < HALF) loN[r] = loN[r] + cExt * vExt;
        else          hiN[r] = hiN[r] + cExt * vExt;
      end
    end
  end

  // Three stages: multiply, pair-sum, rescale and pack
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) begin
        loQ[r]  <= '0;
        hiQ[r]  <= '0;
        sumQ[r] <= '0;
      end
      outQ <= '0;
    end else if (ctl.adv) begin
      for (int r = 0; r < ROWS; r++) begin
        loQ[r]  <= loN[r];
        hiQ[r]  <= hiN[r];
        sumQ[r] <= loQ[r] + hiQ[r];
        outQ[r*LANE_W +: LANE_W] <= LANE_W'(sumQ[r] >>> SHIFT);
      end
    end
  end

  assign outData = outQ;

  AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.running && $past(ctl.running)) |-> $stable(coefQ)); // R11

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.adv |=> $stable(outData)); // R10

endmodule

// File: rtl/vxf_ctrl.sv
module vxf_ctrl
  import vxf_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int ROWS      = 3,
  parameter int ROW_IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [ROW_IDX_W-1:0]  cfgRow,
  input  logic                  cntWe,
  input  logic [CNT_W-1:0]      cntData,
  input  logic                  start,
  input  logic                  inValid,
  output logic                  inReady,
  output logic                  outValid,
  input  logic                  outReady,
  output logic                  busy,
  output logic                  done,
  output dpCtl_t                ctl
);

  logic             running;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] inLeft;
  logic [CNT_W-1:0] outLeft;
  logic             v1, v2, v3;
  logic             doneQ;
  logic             adv, take, outFire, lastOut, startIdle;

  assign adv       = !v3 || outReady;
  assign inReady   = running && (inLeft != '0) && adv;
  assign take      = inValid && inReady;
  assign outFire   = v3 && outReady;
  assign lastOut   = outFire && (outLeft == CNT_W'(1));
  assign startIdle = start && !running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      cntQ    <= '0;
      inLeft  <= '0;
      outLeft <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!running) begin
        if (cntWe) cntQ <= cntData;
        if (startIdle) begin
          if (cntQ == '0) begin
            doneQ <= 1'b1;
          end else begin
            running <= 1'b1;
            inLeft  <= cntQ;
            outLeft <= cntQ;
          end
        end
      end else begin
        if (take)    inLeft  <= inLeft - CNT_W'(1);
        if (outFire) outLeft <= outLeft - CNT_W'(1);
        if (lastOut) begin
          running <= 1'b0;
          doneQ   <= 1'b1;
        end
      end
    end
  end

  // Valid bits travelling alongside the datapath stages
  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= take;
      v2 <= v1;
      v3 <= v2;
    end
  end

  assign outValid    = v3;
  assign busy        = running;
  assign done        = doneQ;
  assign ctl.adv     = adv;
  assign ctl.take    = take;
  assign ctl.cfgLoad = cfgWe && !running && (cfgRow < ROW_IDX_W'(ROWS));
  assign ctl.running = running;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid); // R10

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R7

  AST_IDLE_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!v1 && !v2 && !v3)); // R6

  AST_COUNT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (outLeft >= inLeft)); // R6

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running)) |-> $stable(cntQ)); // R11

endmodule

// File: rtl/vertex_xform.sv
module vertex_xform
  import vxf_pkg::*;
#(
  parameter int LANE_W    = 16,
  parameter int LANES     = 4,
  parameter int ROWS      = 3,
  parameter int SHIFT     = 13,
  parameter int CNT_W     = 16,
  parameter int ROW_IDX_W = $clog2(ROWS + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWe,
  input  logic [ROW_IDX_W-1:0]     cfgRow,
  input  logic [LANE_W*LANES-1:0]  cfgData,
  input  logic                     cntWe,
  input  logic [CNT_W-1:0]         cntData,
  input  logic                     start,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [LANE_W*LANES-1:0]  inData,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [LANE_W*ROWS-1:0]   outData,
  output logic                     busy,
  output logic                     done
);

  dpCtl_t ctl;

  vxf_ctrl #(
    .CNT_W     (CNT_W),
    .ROWS      (ROWS),
    .ROW_IDX_W (ROW_IDX_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgRow   (cfgRow),
    .cntWe    (cntWe),
    .cntData  (cntData),
    .start    (start),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .busy     (busy),
    .done     (done),
    .ctl      (ctl)
  );

  vxf_datapath #(
    .LANE_W    (LANE_W),
    .LANES     (LANES),
    .ROWS      (ROWS),
    .SHIFT     (SHIFT),
    .ROW_IDX_W (ROW_IDX_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .cfgRow  (cfgRow),
    .cfgData (cfgData),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: tb/vertex_xform_test.sv
module vertex_xform_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgRow = '0;
  logic [63:0] cfgData = '0;
  logic        cntWe = 1'b0;
  logic [15:0] cntData = '0;
  logic        start = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [47:0] outData;
  logic        busy;
  logic        done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;
  logic [63:0] mdlCoef [3];

  // Stimulus vertices: lanes {W, Z, Y, X}
  localparam logic [63:0] VECS [16] = '{
    64'h0001_0003_0002_0001, 64'h0001_FFFF_FFFF_FFFF,
    64'h0001_7FFF_7FFF_7FFF, 64'h0001_8000_8000_8000,
    64'h0001_1000_F000_0100, 64'h0001_0000_0000_0000,
    64'h0001_1234_5678_9ABC, 64'h0001_4000_C000_2000,
    64'h0001_00FF_FF00_0F0F, 64'h0001_8000_7FFF_0001,
    64'h0001_0064_FF9C_0032, 64'h0001_2AAA_5555_D555,
    64'h7FFF_0001_0002_0003, 64'h8000_9000_6000_7000,
    64'h0001_FEDC_BA98_7654, 64'h0001_0800_0400_0200
  };

  vertex_xform uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRow(cfgRow), .cfgData(cfgData),
    .cntWe(cntWe), .cntData(cntData), .start(start), .inValid(inValid),
    .inReady(inReady), .inData(inData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 50000 && !finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference transform written from R3, R4 and R5
  function automatic logic [47:0] refXform(input logic [63:0] v);
    logic [47:0] res;
    res = '0;
    for (int r = 0; r < 3; r++) begin
      int lo, hi, s;
      lo = $signed(mdlCoef[r][15:0]) * $signed(v[15:0]) +
           $signed(mdlCoef[r][31:16]) * $signed(v[31:16]);
      hi = $signed(mdlCoef[r][47:32]) * $signed(v[47:32]) +
           $signed(mdlCoef[r][63:48]) * $signed(v[63:48]);
      s = lo + hi;
      s = s >>> 13;
      res[16*r +: 16] = s[15:0];
    end
    return res;
  endfunction

  task automatic loadRow(input int row, input logic [63:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgRow = 2'(row); cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (row < 3) mdlCoef[row] = d;
  endtask

  task automatic setCount(input int n);
    @(negedge clk);
    cntWe = 1'b1; cntData = 16'(n);
    @(negedge clk);
    cntWe = 1'b0;
  endtask

  task automatic runStream(input int n, input int base, input bit bp, input bit midWrite);
    int inIdx = 0;
    int outIdx = 0;
    int inCyc [32];
    int lastOutCyc = -10;
    bit seenDone = 0;
    bit holdPrev = 0;
    logic [47:0] prevData = '0;
    int iter = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!seenDone && iter < 2000) begin
      outReady = bp ? ((iter % 3) != 1) : 1'b1;
      inValid  = 1'b1;
      inData   = VECS[(base + inIdx) % 16];
      if (midWrite && iter == 0) begin
        cfgWe = 1'b1; cfgRow = 2'd0; cfgData = '0;
        cntWe = 1'b1; cntData = 16'd5;
      end else begin
        cfgWe = 1'b0; cntWe = 1'b0;
      end
      #1;
      if (holdPrev)
        chk(outValid && outData == prevData, "R10 hold", {15'd0, outValid, outData}, {16'h0001, prevData});
      if (inValid && inReady) begin
        inCyc[inIdx % 32] = cyc;
        inIdx++;
      end
      if (outValid && outReady) begin
        logic [47:0] e;
        e = refXform(VECS[(base + outIdx) % 16]);
        chk(outData == e, "R3/R4/R5 result", {16'd0, outData}, {16'd0, e});
        if (!bp)
          chk(cyc == inCyc[outIdx % 32] + 3, "R9 latency", 64'(cyc), 64'(inCyc[outIdx % 32] + 3));
        lastOutCyc = cyc;
        outIdx++;
      end
      holdPrev = outValid && !outReady;
      prevData = outData;
      if (done) begin
        seenDone = 1;
        chk(cyc == lastOutCyc + 1, "R7 done timing", 64'(cyc), 64'(lastOutCyc + 1));
      end
      iter++;
      @(negedge clk);
    end
    inValid = 1'b0; outReady = 1'b1; cfgWe = 1'b0; cntWe = 1'b0;
    #1;
    chk(inIdx == n, "R6 accepted", 64'(inIdx), 64'(n));
    chk(outIdx == n, "R6 produced", 64'(outIdx), 64'(n));
    chk(!busy && !done, "R7 single pulse, idle", {62'd0, busy, done}, 64'd0);
    if (!bp && n > 1)
      chk(inCyc[n-1] - inCyc[0] == n - 1, "R9 throughput", 64'(inCyc[n-1] - inCyc[0]), 64'(n - 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!inReady, "R1 inReady", 64'(inReady), 64'd0);
    chk(!outValid, "R1 outValid", 64'(outValid), 64'd0);
    chk(!busy, "R1 busy", 64'(busy), 64'd0);
    chk(!done, "R1 done", 64'(done), 64'd0);
    @(negedge clk) rstN = 1'b1;

    // Main matrix, free-flowing output (R2 lane order, R3..R5, R9)
    loadRow(0, 64'h0064_0000_1000_2000);
    loadRow(1, 64'hFF00_0800_E000_0000);
    loadRow(2, 64'h0010_2000_0000_F000);
    setCount(8);
    runStream(8, 0, 1'b0, 1'b0);

    // Extreme coefficients force 32-bit wrap (R3), with backpressure (R10)
    loadRow(0, 64'h8000_8000_8000_8000);
    loadRow(1, 64'h7FFF_7FFF_7FFF_7FFF);
    loadRow(2, 64'h8000_7FFF_8000_7FFF);
    setCount(16);
    runStream(16, 0, 1'b1, 1'b0);

    // Zero count (R8)
    setCount(0);
    @(negedge clk);
    start = 1'b1; inValid = 1'b1;
    #1 chk(!inReady, "R8 no accept", 64'(inReady), 64'd0);
    @(negedge clk);
    start = 1'b0;
    #1 chk(done && !inReady, "R8 done next cycle", {62'd0, done, inReady}, 64'd2);
    @(negedge clk);
    inValid = 1'b0;
    #1 chk(!done && !busy, "R8 pulse ends", {62'd0, done, busy}, 64'd0);

    // Writes while busy are ignored (R11)
    loadRow(0, 64'h0064_0000_1000_2000);
    loadRow(1, 64'hFF00_0800_E000_0000);
    loadRow(2, 64'h0010_2000_0000_F000);
    setCount(2);
    runStream(2, 3, 1'b0, 1'b1);
    runStream(2, 5, 1'b0, 1'b0);

    // Row index 3 write changes nothing (R2)
    loadRow(3, 64'h1111_2222_3333_4444);
    setCount(1);
    runStream(1, 9, 1'b0, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule